// File: doc/BRIEF.md
# Tagless Hit Filter Cache Controller

This block is the control and metadata logic of a small direct-mapped instruction filter that sits in front of a first-level instruction cache. The filter holds 16 lines of four 32-bit instructions. Before each fetch, the block decides whether the instruction is certain to be resident in the filter. When it is, the word is read from the filter by index alone, with no tag comparison. When it is not, the fetch goes straight to the larger cache in the same cycle, so a filter miss never costs an extra cycle. The filter is then refilled or its link metadata is updated.

Certainty comes from links that are recorded while fetching:
- A per-line "successor" bit says that the next line in modulo order holds the next sequential memory line.
- A per-instruction "target" bit says that the target of a taken transfer from that instruction is resident.
- A per-line back-pointer vector lists the lines whose target bits may point into it, so that those bits can be dropped when the line is replaced.

Each fetch presents a word address, a flag that tells whether it follows the previous fetch by a predicted transfer (otherwise it is the next sequential word), and the larger cache's hit flag and line data. A fetch that uses the larger cache and gets no hit is not accepted. It leaves all state unchanged and is presented again.

Top module: `tagless_filter_ctrl`

## Requirements
- R1: After reset no line is resident. While idle, `use_filter` and `instr_valid` are 0. The first fetch comes from the larger cache (`use_filter`=0).
- R2: The word address is split as follows: word slot = `fetch_waddr[1:0]`, line index = `fetch_waddr[5:2]`, line ID = `fetch_waddr[11:6]`. When `use_filter`=1, `instr` is the stored word at that slot, and `l1_line` and `l1_hit` have no effect.
- R3: A sequential fetch (`fetch_xfer`=0) that follows an accepted fetch from slots 0 to 2 of a line uses the filter.
- R4: A sequential fetch that follows slot 3 uses the filter only if the previous line's successor bit is set. That bit is set when a larger-cache fetch follows slot 3 of line i-1 sequentially into line i.
- R5: A transfer fetch (`fetch_xfer`=1) uses the filter only if the target bit of the previous instruction is set. A transfer fetch served by the larger cache sets that bit, unless the fill evicted the previous instruction's own line.
- R6: Replacing a line clears every target bit in the lines recorded in its back-pointer vector, and clears the successor bit of the line before it.
- R7: A larger-cache fetch whose line is already resident with the same ID (false miss) does not rewrite the filter line.
- R8: A larger-cache fetch with `l1_hit`=0 gives `instr_valid`=0 and changes no state, including the last-fetch pointer.
- R9: A larger-cache fetch with `l1_hit`=1 gives `instr_valid`=1 and `instr` = word `fetch_waddr[1:0]` of `l1_line` (word 0 in bits 31:0). On a true miss it writes the line into the filter at its index with the new ID.
- R10: A true-miss fill clears the new line's own target bits and its own successor bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_waddr | input | 12 | Word address of the fetch |
| fetch_xfer | input | 1 | 1: fetch follows a predicted transfer; 0: next sequential word |
| l1_hit | input | 1 | Larger cache has the line this cycle |
| l1_line | input | 128 | Line data from the larger cache, word 0 in the low bits |
| use_filter | output | 1 | Fetch source select: 1 = filter, 0 = larger cache |
| instr_valid | output | 1 | `instr` carries the fetched word |
| instr | output | 32 | Fetched instruction word |

## Verification
A wrongly set successor or target bit shows up on the very fetch that relies on it. `use_filter` rises where the guarantee does not hold, and `instr` returns an old line's word in the same cycle. A bit that is wrongly left clear shows up as `use_filter`=0 on a loop that should already run from the filter. A pointer or fill written on the wrong cycle shows up one fetch later, either as a wrong source select on the retried or following fetch, or as stale data on the next sequential hit. The directed scenarios are arranged so that every such fault meets a check within a few fetches.

// File: rtl/thic_pkg.sv
package thic_pkg;
    localparam int DEF_LINES   = 16;
    localparam int DEF_WORDS   = 4;
    localparam int DEF_IW      = 32;
    localparam int DEF_WADDR_W = 12;

    typedef enum logic {
        SRC_L1     = 1'b0,
        SRC_FILTER = 1'b1
    } fetch_src_e;
endpackage

// File: rtl/thic_data.sv
module thic_data #(
    parameter int LINES = thic_pkg::DEF_LINES,
    parameter int WORDS = thic_pkg::DEF_WORDS,
    parameter int IW    = thic_pkg::DEF_IW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(LINES)-1:0]      wr_idx,
    input  logic [WORDS-1:0][IW-1:0]      wr_line,
    input  logic [$clog2(LINES)-1:0]      rd_idx,
    input  logic [$clog2(WORDS)-1:0]      rd_word,
    output logic [IW-1:0]                 rd_data
);
    typedef struct packed {
        logic [LINES-1:0][WORDS-1:0][IW-1:0] mem;
    } data_st_t;

    data_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[rd_idx][rd_word];
endmodule

// File: rtl/thic_meta.sv
module thic_meta #(
    parameter int LINES = thic_pkg::DEF_LINES,
    parameter int WORDS = thic_pkg::DEF_WORDS,
    parameter int ID_W  = 6,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc,
    input  logic                          bypass,
    input  logic                          xfer,
    input  logic [IDX_W-1:0]              idx,
    input  logic [OFF_W-1:0]              word,
    input  logic [ID_W-1:0]               id_in,
    output logic                          fill,
    output logic [LINES-1:0]              valid_vec,
    output logic [LINES-1:0]              ns_vec,
    output logic [LINES-1:0][WORDS-1:0]   nt_arr,
    output logic [LINES-1:0][ID_W-1:0]    id_arr,
    output logic                          last_valid,
    output logic [IDX_W-1:0]              last_line,
    output logic [OFF_W-1:0]              last_word
);
    typedef struct packed {
        logic [LINES-1:0]             valid;
        logic [LINES-1:0]             ns;
        logic [LINES-1:0][ID_W-1:0]   id;
        logic [LINES-1:0][LINES-1:0]  tl;
        logic [LINES-1:0][WORDS-1:0]  nt;
        logic                         last_valid;
        logic [IDX_W-1:0]             last_line;
        logic [OFF_W-1:0]             last_word;
    } meta_st_t;

    meta_st_t st_d, st_q;

    logic             present;
    logic [IDX_W-1:0] pred_idx;
    logic             src_kept;
    logic             from_tail;

    always_comb begin
        present   = st_q.valid[idx] && (st_q.id[idx] == id_in);
        fill      = acc && bypass && !present;
        pred_idx  = idx - IDX_W'(1);
        src_kept  = !(fill && (st_q.last_line == idx));
        from_tail = (st_q.last_word == OFF_W'(WORDS - 1)) && (st_q.last_line == pred_idx);

        st_d = st_q;
        if (acc) begin
            if (bypass) begin
                if (!present) begin
                    // true miss: install the new line and drop links into the old one
                    st_d.valid[idx] = 1'b1;
                    st_d.id[idx]    = id_in;
                    st_d.ns[idx]    = 1'b0;
                    st_d.nt[idx]    = '0;
                    for (int j = 0; j < LINES; j++) begin
                        if (st_q.tl[idx][j]) begin
                            st_d.nt[j] = '0;
                        end
                    end
                    st_d.tl[idx]      = '0;
                    st_d.ns[pred_idx] = 1'b0;
                end
                // record the link from the previous instruction
                if (st_q.last_valid && src_kept) begin
                    if (xfer) begin
                        st_d.nt[st_q.last_line][st_q.last_word] = 1'b1;
                        st_d.tl[idx][st_q.last_line]            = 1'b1;
                    end else if (from_tail) begin
                        st_d.ns[st_q.last_line] = 1'b1;
                    end
                end
            end
            st_d.last_valid = 1'b1;
            st_d.last_line  = idx;
            st_d.last_word  = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_vec  = st_q.valid;
    assign ns_vec     = st_q.ns;
    assign nt_arr     = st_q.nt;
    assign id_arr     = st_q.id;
    assign last_valid = st_q.last_valid;
    assign last_line  = st_q.last_line;
    assign last_word  = st_q.last_word;
endmodule

// File: rtl/thic_decide.sv
module thic_decide #(
    parameter int LINES = thic_pkg::DEF_LINES,
    parameter int WORDS = thic_pkg::DEF_WORDS,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                          last_valid,
    input  logic [IDX_W-1:0]              last_line,
    input  logic [OFF_W-1:0]              last_word,
    input  logic                          xfer,
    input  logic [LINES-1:0]              ns_vec,
    input  logic [LINES-1:0][WORDS-1:0]   nt_arr,
    output thic_pkg::fetch_src_e          src
);
    import thic_pkg::*;

    logic at_tail;

    always_comb begin
        at_tail = (last_word == OFF_W'(WORDS - 1));
        src     = SRC_L1;
        if (last_valid) begin
            if (xfer) begin
                src = nt_arr[last_line][last_word] ? SRC_FILTER : SRC_L1;
            end else if (!at_tail) begin
                src = SRC_FILTER;
            end else begin
                src = ns_vec[last_line] ? SRC_FILTER : SRC_L1;
            end
        end
    end
endmodule

// File: rtl/tagless_filter_ctrl.sv
module tagless_filter_ctrl #(
    parameter int LINES   = thic_pkg::DEF_LINES,
    parameter int WORDS   = thic_pkg::DEF_WORDS,
    parameter int IW      = thic_pkg::DEF_IW,
    parameter int WADDR_W = thic_pkg::DEF_WADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_valid,
    input  logic [WADDR_W-1:0]     fetch_waddr,
    input  logic                   fetch_xfer,
    input  logic                   l1_hit,
    input  logic [WORDS*IW-1:0]    l1_line,
    output logic                   use_filter,
    output logic                   instr_valid,
    output logic [IW-1:0]          instr
);
    import thic_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int ID_W  = WADDR_W - IDX_W - OFF_W;

    logic [OFF_W-1:0]             word_sel;
    logic [IDX_W-1:0]             line_idx;
    logic [ID_W-1:0]              id_in;
    logic [WORDS-1:0][IW-1:0]     l1_words;
    fetch_src_e                   src;
    logic                         acc;
    logic                         fill;
    logic [LINES-1:0]             valid_vec;
    logic [LINES-1:0]             ns_vec;
    logic [LINES-1:0][WORDS-1:0]  nt_arr;
    logic [LINES-1:0][ID_W-1:0]   id_arr;
    logic                         last_valid;
    logic [IDX_W-1:0]             last_line;
    logic [OFF_W-1:0]             last_word;
    logic [IW-1:0]                filt_word;

    assign word_sel = fetch_waddr[OFF_W-1:0];
    assign line_idx = fetch_waddr[OFF_W +: IDX_W];
    assign id_in    = fetch_waddr[WADDR_W-1 -: ID_W];
    assign l1_words = l1_line;

    thic_decide #(.LINES(LINES), .WORDS(WORDS)) u_decide (
        .last_valid (last_valid),
        .last_line  (last_line),
        .last_word  (last_word),
        .xfer       (fetch_xfer),
        .ns_vec     (ns_vec),
        .nt_arr     (nt_arr),
        .src        (src)
    );

    assign use_filter  = fetch_valid && (src == SRC_FILTER);
    assign acc         = fetch_valid && (use_filter || l1_hit);
    assign instr_valid = acc;

    thic_meta #(.LINES(LINES), .WORDS(WORDS), .ID_W(ID_W)) u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .bypass     (!use_filter),
        .xfer       (fetch_xfer),
        .idx        (line_idx),
        .word       (word_sel),
        .id_in      (id_in),
        .fill       (fill),
        .valid_vec  (valid_vec),
        .ns_vec     (ns_vec),
        .nt_arr     (nt_arr),
        .id_arr     (id_arr),
        .last_valid (last_valid),
        .last_line  (last_line),
        .last_word  (last_word)
    );

    thic_data #(.LINES(LINES), .WORDS(WORDS), .IW(IW)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill),
        .wr_idx  (line_idx),
        .wr_line (l1_words),
        .rd_idx  (line_idx),
        .rd_word (word_sel),
        .rd_data (filt_word)
    );

    assign instr = use_filter ? filt_word : l1_words[word_sel];
endmodule

// File: rtl/thic_chk.sv
module thic_chk #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int ID_W  = 6,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         fetch_valid,
    input logic                         use_filter,
    input logic                         l1_hit,
    input logic [IDX_W-1:0]             line_idx,
    input logic [ID_W-1:0]              id_in,
    input logic [LINES-1:0]             valid_vec,
    input logic [LINES-1:0]             ns_vec,
    input logic [LINES-1:0][WORDS-1:0]  nt_arr,
    input logic [LINES-1:0][ID_W-1:0]   id_arr
);
    // R2: a filter-sourced fetch always finds its line resident under the right ID
    p_guaranteed_resident_r2: assert property (@(posedge clk) disable iff (!rst_n)
        use_filter |-> (valid_vec[line_idx] && (id_arr[line_idx] == id_in)));

    // R9: an accepted larger-cache fetch leaves its line resident with its ID
    p_fill_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !use_filter && l1_hit) |=>
            (valid_vec[$past(line_idx)] && (id_arr[$past(line_idx)] == $past(id_in))));

    // R8: a fetch stalled on the larger cache leaves the link state alone
    p_stall_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !use_filter && !l1_hit) |=>
            ($stable(valid_vec) && $stable(ns_vec) && $stable(nt_arr) && $stable(id_arr)));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int NX = (i + 1) % LINES;

        // R4: a successor bit only links two resident, memory-consecutive lines
        p_ns_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ns_vec[i] |-> (valid_vec[i] && valid_vec[NX] &&
                ({id_arr[NX], IDX_W'(NX)} ==
                 ({id_arr[i], IDX_W'(i)} + (ID_W + IDX_W)'(1)))));

        // R5: target bits only live in resident lines
        p_nt_in_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (|nt_arr[i]) |-> valid_vec[i]);
    end
endmodule

bind tagless_filter_ctrl thic_chk #(
    .LINES (LINES),
    .WORDS (WORDS),
    .ID_W  (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .use_filter  (use_filter),
    .l1_hit      (l1_hit),
    .line_idx    (line_idx),
    .id_in       (id_in),
    .valid_vec   (valid_vec),
    .ns_vec      (ns_vec),
    .nt_arr      (nt_arr),
    .id_arr      (id_arr)
);

// File: tb/tb_tagless_filter_ctrl.sv
`timescale 1ns/1ps
module tb_tagless_filter_ctrl;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         fetch_valid;
    logic [11:0]  fetch_waddr;
    logic         fetch_xfer;
    logic         l1_hit;
    logic [127:0] l1_line;
    logic         use_filter;
    logic         instr_valid;
    logic [31:0]  instr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tagless_filter_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_waddr (fetch_waddr),
        .fetch_xfer  (fetch_xfer),
        .l1_hit      (l1_hit),
        .l1_line     (l1_line),
        .use_filter  (use_filter),
        .instr_valid (instr_valid),
        .instr       (instr)
    );

    function automatic logic [31:0] wd(input logic [13:0] a, input logic [7:0] salt);
        return {salt, 12'h000, a[13:4], a[3:2]};
    endfunction

    function automatic logic [127:0] mkline(input logic [13:0] a, input logic [7:0] salt);
        logic [13:0] base = {a[13:4], 4'h0};
        return {wd(base + 14'd12, salt), wd(base + 14'd8, salt),
                wd(base + 14'd4, salt), wd(base, salt)};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_waddr = '0; fetch_xfer = 1'b0;
        l1_hit = 1'b0; l1_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "idle use_filter", 32'(use_filter), 32'd0);
        chk("R1", "idle instr_valid", 32'(instr_valid), 32'd0);
        @(posedge clk);
    endtask

    // one fetch: drive at the falling edge, check before the next rising edge
    task automatic fx(input logic [13:0] a, input logic xf, input logic hit, input logic [7:0] l1_salt,
                      input logic exp_uf, input logic exp_iv, input logic [7:0] exp_salt, input string req);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_waddr = a[13:2]; fetch_xfer = xf;
        l1_hit = hit; l1_line = mkline(a, l1_salt);
        #1;
        chk(req, $sformatf("use_filter @%h", a), 32'(use_filter), 32'(exp_uf));
        chk(req, $sformatf("instr_valid @%h", a), 32'(instr_valid), 32'(exp_iv));
        if (exp_iv) chk(req, $sformatf("instr @%h", a), instr, wd(a, exp_salt));
        @(posedge clk);
        #0.5;
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset_and_seq();   // R1 R9 R2 R3 R4
        do_reset();
        fx(14'h100, 0, 1, 8'hA1, 0, 1, 8'hA1, "R1");
        fx(14'h104, 0, 1, 8'hB2, 1, 1, 8'hA1, "R3");
        fx(14'h108, 0, 0, 8'hB2, 1, 1, 8'hA1, "R2");
        fx(14'h10C, 0, 1, 8'hB2, 1, 1, 8'hA1, "R3");
        fx(14'h110, 0, 1, 8'hC3, 0, 1, 8'hC3, "R4");
        fx(14'h114, 0, 1, 8'hB2, 1, 1, 8'hC3, "R9");
        fx(14'h118, 0, 1, 8'hB2, 1, 1, 8'hC3, "R3");
        fx(14'h11C, 0, 1, 8'hB2, 1, 1, 8'hC3, "R3");
    endtask

    task automatic t_loop();   // R5 R7 R4, continues previous state
        fx(14'h100, 1, 1, 8'hD4, 0, 1, 8'hD4, "R5");
        fx(14'h104, 0, 1, 8'hD4, 1, 1, 8'hA1, "R7");
        fx(14'h108, 0, 1, 8'hD4, 1, 1, 8'hA1, "R3");
        fx(14'h10C, 0, 1, 8'hD4, 1, 1, 8'hA1, "R3");
        fx(14'h110, 0, 1, 8'hD4, 1, 1, 8'hC3, "R4");
        fx(14'h114, 0, 1, 8'hD4, 1, 1, 8'hC3, "R3");
        fx(14'h118, 0, 1, 8'hD4, 1, 1, 8'hC3, "R3");
        fx(14'h11C, 0, 1, 8'hD4, 1, 1, 8'hC3, "R3");
        fx(14'h100, 1, 1, 8'hD4, 1, 1, 8'hA1, "R5");
    endtask

    task automatic t_target_kill();   // R6, continues previous state
        fx(14'h104, 0, 1, 8'hD4, 1, 1, 8'hA1, "R3");
        fx(14'h500, 1, 1, 8'hE5, 0, 1, 8'hE5, "R9");
        fx(14'h11C, 1, 1, 8'hF6, 0, 1, 8'hF6, "R5");
        fx(14'h100, 1, 1, 8'h17, 0, 1, 8'h17, "R6");
        fx(14'h104, 0, 1, 8'hF6, 1, 1, 8'h17, "R9");
    endtask

    task automatic t_succ_kill();   // R6 R4
        do_reset();
        fx(14'h10C, 0, 1, 8'hA1, 0, 1, 8'hA1, "R1");
        fx(14'h110, 0, 1, 8'hB2, 0, 1, 8'hB2, "R4");
        fx(14'h510, 1, 1, 8'hC3, 0, 1, 8'hC3, "R5");
        fx(14'h10C, 1, 1, 8'hD4, 0, 1, 8'hD4, "R10");
        fx(14'h110, 0, 1, 8'hE5, 0, 1, 8'hE5, "R6");
        fx(14'h114, 0, 1, 8'hB2, 1, 1, 8'hE5, "R4");
    endtask

    task automatic t_own_clear();   // R10
        do_reset();
        fx(14'h104, 0, 1, 8'hA1, 0, 1, 8'hA1, "R1");
        fx(14'h130, 1, 1, 8'hB2, 0, 1, 8'hB2, "R5");
        fx(14'h104, 1, 1, 8'hC3, 0, 1, 8'hC3, "R5");
        fx(14'h108, 0, 1, 8'hC3, 1, 1, 8'hA1, "R7");
        fx(14'h500, 1, 1, 8'hD4, 0, 1, 8'hD4, "R9");
        fx(14'h504, 0, 1, 8'hC3, 1, 1, 8'hD4, "R3");
        fx(14'h130, 1, 1, 8'hE5, 0, 1, 8'hE5, "R10");
    endtask

    task automatic t_stall();   // R8
        do_reset();
        fx(14'h100, 0, 0, 8'hA1, 0, 0, 8'hA1, "R8");
        fx(14'h100, 0, 1, 8'hA1, 0, 1, 8'hA1, "R8");
        fx(14'h104, 0, 1, 8'hB2, 1, 1, 8'hA1, "R3");
        fx(14'h108, 0, 1, 8'hB2, 1, 1, 8'hA1, "R3");
        fx(14'h10C, 0, 1, 8'hB2, 1, 1, 8'hA1, "R3");
        fx(14'h110, 0, 0, 8'hB2, 0, 0, 8'hB2, "R8");
        fx(14'h110, 0, 1, 8'hB2, 0, 1, 8'hB2, "R8");
        @(negedge clk);
        #1;
        chk("R8", "idle use_filter", 32'(use_filter), 32'd0);
        chk("R8", "idle instr_valid", 32'(instr_valid), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_waddr = '0; fetch_xfer = 1'b0;
        l1_hit = 1'b0; l1_line = '0;
        t_reset_and_seq();
        t_loop();
        t_target_kill();
        t_succ_kill();
        t_own_clear();
        t_stall();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            finish_run();
        end
    end
endmodule